// File: doc/BRIEF.md
# Two-Level Global-History Branch Direction Predictor

The block predicts whether a conditional branch will be taken. It keeps a table of 2-bit predictor entries, split into four sets. The low `IDX_W` bits of the fetch address pick an entry inside a set. A 2-bit global history register, holding the outcomes of the last two resolved branches, picks the set. A lookup is purely combinational. The fetch stage presents an address and gets back the predicted direction together with the history value in force. It keeps that history value with the branch.

When the branch resolves, the pipeline issues an update carrying four things:

- the branch address,
- the history value captured at prediction time,
- the actual outcome,
- a valid strobe.

The update rewrites the addressed entry and shifts the outcome into the global history. Each entry holds a predicted direction and a flag recording whether the last prediction from that entry was wrong. The direction flips only after two mispredictions in a row.

Top module: `dirpred_top`

## Requirements
- R1: After reset the global history is 00 and every entry is not-taken with the "last prediction right" state, so every lookup returns 0.
- R2: `lk_taken` combinationally gives the direction bit (1 = taken) of the entry at set = current history and index = `lk_pc[IDX_W-1:0]`. `lk_hist` shows the current history.
- R3: On a clock edge with `up_valid` high, the history becomes `{old_history[0], up_taken}`, where taken is 1. Without `up_valid` the history holds its value.
- R4: An update whose outcome equals the entry's direction keeps the direction and sets the state to "right". A following single misprediction therefore does not flip it.
- R5: An update that mispredicts an entry in the "right" state keeps its direction and sets the state to "wrong".
- R6: An update that mispredicts an entry in the "wrong" state inverts its direction and sets the state to "right".
- R7: An update writes only the entry at set = `up_hist` and index = `up_pc[IDX_W-1:0]`, whatever the current history is. All other entries are unchanged.
- R8: A lookup in the same cycle as an update to the same entry returns the entry's value from before that update.
- R9: Address bits at and above `IDX_W` have no effect on lookup or update.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| lk_pc | input | PC_W | Fetch address to predict |
| lk_taken | output | 1 | Predicted direction, 1 = taken |
| lk_hist | output | 2 | Current global history, to be kept with the branch |
| up_valid | input | 1 | Resolved-branch update strobe |
| up_pc | input | PC_W | Address of the resolved branch |
| up_hist | input | 2 | History captured when the branch was predicted |
| up_taken | input | 1 | Actual outcome, 1 = taken |

## Verification
A wrong direction bit shows at `lk_taken` as soon as that set and index are looked up. A wrong "last prediction right/wrong" flag is hidden until the next misprediction of that entry. It then either flips the direction one mistake early or leaves it one mistake late. The bench drives single and double mispredictions, then steers the history back to reach each entry. A history register that shifts wrongly shows on `lk_hist` one cycle after the update, and it also redirects every later lookup to the wrong set.

// File: rtl/dirpred_pkg.sv
// Package: shared entry type and next-state rule for the direction predictor.
// Assumes one update per entry per cycle; the rule is pure combinational.
package dirpred_pkg;

    localparam int HIST_W = 2;

    // One predictor entry: predicted direction and last-prediction-wrong flag.
    typedef struct packed {
        logic dir;
        logic miss;
    } ctr_t;

    // Next entry value given the actual outcome of the branch.
    function automatic ctr_t ctr_next(ctr_t cur, logic taken);
        ctr_t nxt;
        if (cur.dir == taken) begin
            nxt.dir  = cur.dir;
            nxt.miss = 1'b0;
        end else if (!cur.miss) begin
            nxt.dir  = cur.dir;
            nxt.miss = 1'b1;
        end else begin
            nxt.dir  = ~cur.dir;
            nxt.miss = 1'b0;
        end
        return nxt;
    endfunction

endpackage

// File: rtl/dirpred_history.sv
// Module: global outcome history shift register.
// Shifts in the resolved outcome on every valid update; clears on reset.
module dirpred_history #(
    parameter int HIST_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              shift_en,
    input  logic              bit_in,
    output logic [HIST_W-1:0] hist
);

    // Shift register update with synchronous active-low reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hist <= '0;
        end else if (shift_en) begin
            hist <= {hist[HIST_W-2:0], bit_in};
        end
    end

    // R3: newest outcome enters at bit 0, previous bit 0 moves up.
    assert_hist_shift_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (rst_n && shift_en) |=> (hist[0] == $past(bit_in)) && (hist[1] == $past(hist[0])));

    // R3: history holds when no update is presented.
    assert_hist_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (rst_n && !shift_en) |=> $stable(hist));

endmodule

// File: rtl/dirpred_table.sv
// Module: predictor entry storage, one read port and one update port.
// Read is combinational and sees the pre-edge contents; the write lands at the edge.
module dirpred_table
    import dirpred_pkg::*;
#(
    parameter int AW = 6
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [AW-1:0] rd_idx,
    output ctr_t          rd_entry,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_idx,
    input  logic          wr_taken
);

    localparam int DEPTH = 1 << AW;

    ctr_t mem [DEPTH];
    ctr_t cur;

    // Combinational read of the lookup entry and of the entry being updated.
    always_comb begin
        rd_entry = mem[rd_idx];
        cur      = mem[wr_idx];
    end

    // Entry update on a resolved branch; reset sets every entry to not-taken/right.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) begin
                mem[i] <= '0;
            end
        end else if (wr_en) begin
            mem[wr_idx] <= ctr_next(cur, wr_taken);
        end
    end

    // R4: a correct outcome leaves the direction and clears the wrong flag.
    assert_correct_clears_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (rst_n && wr_en && (cur.dir == wr_taken)) |=>
        (mem[$past(wr_idx)].miss == 1'b0) && (mem[$past(wr_idx)].dir == $past(cur.dir)));

    // R5: a misprediction from the right state never flips the direction.
    assert_first_miss_keeps_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (rst_n && wr_en && !cur.miss && (cur.dir != wr_taken)) |=>
        (mem[$past(wr_idx)].dir == $past(cur.dir)) && mem[$past(wr_idx)].miss);

    // R6: a misprediction from the wrong state flips the direction.
    assert_second_miss_flips_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (rst_n && wr_en && cur.miss && (cur.dir != wr_taken)) |=>
        (mem[$past(wr_idx)].dir != $past(cur.dir)) && !mem[$past(wr_idx)].miss);

    // R8: without an update, the entry under lookup keeps its value.
    assert_idle_stable_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (rst_n && !wr_en) |=> (mem[$past(rd_idx)] == $past(rd_entry)));

endmodule

// File: rtl/dirpred_top.sv
// Module: two-level global-history branch direction predictor top.
// Assumes the caller returns, with each update, the history it read at lookup.
module dirpred_top
    import dirpred_pkg::*;
#(
    parameter int PC_W  = 32,
    parameter int IDX_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [PC_W-1:0]   lk_pc,
    output logic              lk_taken,
    output logic [HIST_W-1:0] lk_hist,
    input  logic              up_valid,
    input  logic [PC_W-1:0]   up_pc,
    input  logic [HIST_W-1:0] up_hist,
    input  logic              up_taken
);

    localparam int AW = HIST_W + IDX_W;

    logic [HIST_W-1:0] ghist;
    logic [AW-1:0]     rd_idx;
    logic [AW-1:0]     wr_idx;
    ctr_t              rd_entry;
    logic              unused_pc_hi;

    // Form table addresses: history selects the set, low PC bits the entry.
    always_comb begin
        rd_idx       = {ghist, lk_pc[IDX_W-1:0]};
        wr_idx       = {up_hist, up_pc[IDX_W-1:0]};
        unused_pc_hi = ^{lk_pc[PC_W-1:IDX_W], up_pc[PC_W-1:IDX_W]};
        lk_taken     = rd_entry.dir;
        lk_hist      = ghist;
    end

    dirpred_history #(.HIST_W(HIST_W)) u_hist (
        .clk      (clk),
        .rst_n    (rst_n),
        .shift_en (up_valid),
        .bit_in   (up_taken),
        .hist     (ghist)
    );

    dirpred_table #(.AW(AW)) u_table (
        .clk      (clk),
        .rst_n    (rst_n),
        .rd_idx   (rd_idx),
        .rd_entry (rd_entry),
        .wr_en    (up_valid),
        .wr_idx   (wr_idx),
        .wr_taken (up_taken)
    );

    // R1: the cycle after reset, history is clear and the lookup predicts not-taken.
    assert_reset_state_R1: assert property (@(posedge clk)
        !rst_n |=> (lk_hist == '0) && !lk_taken);

endmodule

// File: tb/dirpred_top_test.sv
// Bench: directed scenarios plus a model-checked sweep for the direction predictor.
module dirpred_top_test;

    localparam int CLK_PERIOD = 10;
    localparam int PC_W  = 32;
    localparam int IDX_W = 4;
    localparam int NENT  = 4 << IDX_W;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic [PC_W-1:0] lk_pc = '0;
    logic            lk_taken;
    logic [1:0]      lk_hist;
    logic            up_valid = 1'b0;
    logic [PC_W-1:0] up_pc = '0;
    logic [1:0]      up_hist = '0;
    logic            up_taken = 1'b0;

    int n_chk = 0;
    int n_bad = 0;

    // Bench model: entry bit1 = direction (1 taken), bit0 = last prediction wrong.
    logic [1:0] mdl [NENT];
    logic [1:0] mghr = 2'b00;

    always #(CLK_PERIOD/2) clk = ~clk;

    dirpred_top #(.PC_W(PC_W), .IDX_W(IDX_W)) uut (
        .clk(clk), .rst_n(rst_n), .lk_pc(lk_pc), .lk_taken(lk_taken), .lk_hist(lk_hist),
        .up_valid(up_valid), .up_pc(up_pc), .up_hist(up_hist), .up_taken(up_taken)
    );

    task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    function automatic logic [1:0] mnext(logic [1:0] e, logic t);
        if (e[1] == t) return {e[1], 1'b0};
        else if (!e[0]) return {e[1], 1'b1};
        else return {~e[1], 1'b0};
    endfunction

    // Apply one update for one cycle and advance the model.
    task automatic do_update(input logic [PC_W-1:0] pc, input logic [1:0] h, input logic t);
        int idx;
        @(negedge clk);
        up_valid = 1'b1; up_pc = pc; up_hist = h; up_taken = t;
        @(negedge clk);
        up_valid = 1'b0;
        idx = {h, pc[IDX_W-1:0]};
        mdl[idx] = mnext(mdl[idx], t);
        mghr = {mghr[0], t};
    endtask

    // Drive history back to 00 with two correct not-taken updates on an idle entry.
    task automatic zero_hist();
        do_update(32'd15, 2'd3, 1'b0);
        do_update(32'd15, 2'd3, 1'b0);
    endtask

    // Look up an address while the clock is low and compare with an explicit value.
    task automatic look(input logic [PC_W-1:0] pc, input logic exp, input string tag);
        lk_pc = pc;
        #1;
        chk({31'd0, lk_taken}, {31'd0, exp}, tag);
    endtask

    task automatic t_reset();
        chk({30'd0, lk_hist}, 32'd0, "R1 history after reset");
        for (int i = 0; i < (1 << IDX_W); i++) look(i, 1'b0, "R1 entry after reset");
    endtask

    task automatic t_two_miss();
        do_update(32'd5, 2'd0, 1'b1); zero_hist(); look(32'd5, 1'b0, "R5 single miss keeps NT");
        do_update(32'd5, 2'd0, 1'b1); zero_hist(); look(32'd5, 1'b1, "R6 second miss flips to T");
        do_update(32'd5, 2'd0, 1'b0); zero_hist(); look(32'd5, 1'b1, "R5 single miss keeps T");
        do_update(32'd5, 2'd0, 1'b0); zero_hist(); look(32'd5, 1'b0, "R6 second miss flips to NT");
        do_update(32'd5, 2'd0, 1'b1); do_update(32'd5, 2'd0, 1'b1); zero_hist();
        look(32'd5, 1'b1, "R6 relearn taken");
    endtask

    task automatic t_set_select();
        do_update(32'd9, 2'd0, 1'b1);
        chk({30'd0, lk_hist}, 32'd1, "R3 history after taken");
        look(32'd5, 1'b0, "R2 set 1 separate from set 0");
        do_update(32'd9, 2'd0, 1'b0);
        chk({30'd0, lk_hist}, 32'd2, "R3 history after not-taken");
        look(32'd5, 1'b0, "R2 set 2 separate from set 0");
        zero_hist();
        look(32'd5, 1'b1, "R2 set 0 still taken");
    endtask

    task automatic t_update_hist();
        do_update(32'd7, 2'd2, 1'b1); do_update(32'd7, 2'd2, 1'b1);
        chk({30'd0, lk_hist}, 32'd3, "R3 history 11");
        look(32'd7, 1'b0, "R7 set 3 untouched");
        do_update(32'd15, 2'd3, 1'b0);
        look(32'd7, 1'b1, "R7 write went to supplied set 2");
        zero_hist();
        look(32'd7, 1'b0, "R7 set 0 untouched");
    endtask

    task automatic t_correct_clears();
        do_update(32'd11, 2'd0, 1'b1);
        do_update(32'd11, 2'd0, 1'b0);
        do_update(32'd11, 2'd0, 1'b1);
        zero_hist();
        look(32'd11, 1'b0, "R4 correct outcome reset wrong flag");
    endtask

    task automatic t_same_cycle();
        int idx;
        @(negedge clk);
        lk_pc = 32'd11; up_valid = 1'b1; up_pc = 32'd11; up_hist = 2'd0; up_taken = 1'b1;
        #1;
        chk({31'd0, lk_taken}, 32'd0, "R8 lookup sees pre-update value");
        @(negedge clk);
        up_valid = 1'b0;
        idx = {2'd0, 4'd11};
        mdl[idx] = mnext(mdl[idx], 1'b1);
        mghr = {mghr[0], 1'b1};
        zero_hist();
        look(32'd11, 1'b1, "R8 update landed after edge");
    endtask

    task automatic t_idle_hold();
        logic [1:0] h0;
        do_update(32'd3, 2'd1, 1'b1);
        h0 = lk_hist;
        repeat (4) @(negedge clk);
        chk({30'd0, lk_hist}, {30'd0, h0}, "R3 history holds without update");
        zero_hist();
    endtask

    task automatic t_high_bits();
        look(32'hABCD_0005, 1'b1, "R9 high bits ignored on lookup");
        look(32'h0000_0015, 1'b1, "R9 alias of index 5");
        do_update(32'hFFFF_FFF7, 2'd0, 1'b1);
        do_update(32'h1234_5677, 2'd0, 1'b1);
        zero_hist();
        look(32'd7, 1'b1, "R9 high bits ignored on update");
    endtask

    task automatic t_sweep();
        logic [15:0] lf = 16'hACE1;
        for (int n = 0; n < 400; n++) begin
            lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
            lk_pc = {16'h0, lf};
            #1;
            chk({31'd0, lk_taken}, {31'd0, mdl[{mghr, lf[IDX_W-1:0]}][1]}, "R2 sweep lookup");
            chk({30'd0, lk_hist}, {30'd0, mghr}, "R3 sweep history");
            do_update({lf, 16'h0} | {28'h0, lf[7:4]}, lf[9:8], lf[11] ^ lf[2]);
        end
    endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: run did not finish");
        summary();
        $finish;
    end

    initial begin
        for (int i = 0; i < NENT; i++) mdl[i] = 2'b00;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_two_miss();
        t_set_select();
        t_update_hist();
        t_correct_clears();
        t_same_cycle();
        t_idle_hold();
        t_high_bits();
        t_sweep();
        summary();
        $finish;
    end

endmodule